// File: doc/BRIEF.md
# PLL Bring-up and Lock Sequencer

This block powers up a clocking subsystem once its divider settings are known. A start request first lifts the isolation gasket and releases the core from reset. The block then checks that the PLL output divider is in divide-by-2 mode, loads the feedback divider and the core and MCU clock-control words, and takes the PLL through a fixed sequence: bypass on, reset on, reset off. After that it waits for the lock indication for a bounded number of cycles. On lock it takes the PLL out of bypass and reports done. If lock never arrives, it reports a timeout and leaves bypass set. A stop request returns the subsystem to the isolated, held-in-reset state from any point.

The analog PLL is represented only by the `lock_i` input. Two parameters set the timing in clock cycles: the minimum reset pulse length (`RST_HOLD`) and the lock wait budget (`LOCK_TIMEOUT`). The default budget corresponds to two seconds at 200 MHz.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, `gasket_o` is 0 and `busy_o`, `done_o`, `err_timeout_o` and `err_cfg_o` are 0. In `pll_ctrl_o`, reset (bit 0) and bypass (bit 3) are 0, both power-on-reset bits (bits 1 and 2) are 1, and the feedback field (bits 14:8) is 0. Both clock-control words are 0.
- R2: A start request seen at edge E0 while the block is idle, done or failed sets `gasket_o` to 2'b11 after E0: bit 0 lifts isolation and bit 1 releases the core reset. `busy_o` is 1 from E0 until the sequence ends.
- R3: At edge E1 the output divide field (`outdiv_i`, shown at `pll_ctrl_o[17:16]`) must equal 1. If it does not, `err_cfg_o` rises after E1, `busy_o` falls, and `pll_ctrl_o[15:0]` and both clock-control words keep their prior values.
- R4: With a valid divide field, after E1 `pll_ctrl_o[14:8]` holds `fbdiv_i`, bits 1 and 2 are 0, and each clock-control word has source select bit 0 = 1 with its 6-bit divisor at bits 9:4.
- R5: Bypass (bit 3) rises after E2, one edge before the PLL reset bit (bit 0) rises after E3. Bypass is 1 whenever reset is 1.
- R6: The PLL reset bit stays 1 for exactly `RST_HOLD` cycles and falls after edge E3+`RST_HOLD`.
- R7: `lock_i` is sampled only from edge E4+`RST_HOLD` onward. A lock pulse that ends before that edge has no effect.
- R8: When a sampled `lock_i` is 1, bypass clears, `done_o` rises and `busy_o` falls after that same edge.
- R9: If none of the `LOCK_TIMEOUT` lock samples is 1, `err_timeout_o` rises after edge E3+`RST_HOLD`+`LOCK_TIMEOUT`, bypass stays 1 and `done_o` stays 0. A lock seen at that last edge still counts as success.
- R10: A stop request in any state sets `gasket_o` to 0 and clears `busy_o`, `done_o` and both error flags after that edge. Stop takes priority over a simultaneous start.
- R11: A start request while `busy_o` is 1 is ignored and the running sequence keeps its timing. Start is accepted again after done or an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin bring-up request |
| stop_i | input | 1 | Teardown request |
| lock_i | input | 1 | PLL lock indication |
| fbdiv_i | input | 7 | Feedback divider to load |
| core_div_i | input | 6 | Core clock divisor |
| mcu_div_i | input | 6 | MCU clock divisor |
| outdiv_i | input | 2 | Current PLL output divide field |
| pll_ctrl_o | output | 18 | PLL control word (reset, POR bits, bypass, feedback, output divide) |
| core_clk_ctrl_o | output | 10 | Core clock-control word |
| mcu_clk_ctrl_o | output | 10 | MCU clock-control word |
| gasket_o | output | 2 | Gasket control: bit 0 isolation lifted, bit 1 core out of reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | PLL locked, bypass removed |
| err_timeout_o | output | 1 | Lock not seen within budget |
| err_cfg_o | output | 1 | Output divide field invalid |

## Verification
The bench builds the block with `RST_HOLD` = 3 and `LOCK_TIMEOUT` = 24. With these values a whole sequence takes about thirty cycles. The timeout path and the lock decision at the last and first-past-last samples are therefore cheap to reach, and dozens of random runs fit in the budget. The short hold also puts the boundary between ignored early lock pulses and the first counted sample within a few cycles of start, where directed cases place pulses on either side of it.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_BYPASS,
    S_RSTON,
    S_HOLD,
    S_WAIT,
    S_DONE,
    S_ERR
  } pbs_state_t;

  // PLL control word layout (decoded by the PLL wrapper)
  localparam int CTRL_W     = 18;
  localparam int RST_BIT    = 0;
  localparam int PORIN_BIT  = 1;
  localparam int PWRPOR_BIT = 2;
  localparam int BYP_BIT    = 3;
  localparam int FB_LSB     = 8;
  localparam int FB_W       = 7;
  localparam int OD_LSB     = 16;
  localparam int OD_W       = 2;

  // Clock-control word layout
  localparam int CLKW_W     = 10;
  localparam int SRC_BIT    = 0;
  localparam int DIV_LSB    = 4;
  localparam int DIV_W      = 6;

  localparam logic [1:0]      GASKET_ON  = 2'b11;
  localparam logic [1:0]      GASKET_OFF = 2'b00;
  localparam logic [OD_W-1:0] OD_DIV2    = 2'd1;

  function automatic logic [CTRL_W-1:0] pll_word(
    input logic            r,
    input logic            por_in,
    input logic            pwr_por,
    input logic            byp,
    input logic [FB_W-1:0] fb,
    input logic [OD_W-1:0] od
  );
    logic [CTRL_W-1:0] v;
    v                   = '0;
    v[RST_BIT]          = r;
    v[PORIN_BIT]        = por_in;
    v[PWRPOR_BIT]       = pwr_por;
    v[BYP_BIT]          = byp;
    v[FB_LSB +: FB_W]   = fb;
    v[OD_LSB +: OD_W]   = od;
    return v;
  endfunction

  function automatic logic [CLKW_W-1:0] clk_word(input logic [DIV_W-1:0] div);
    logic [CLKW_W-1:0] v;
    v                   = '0;
    v[SRC_BIT]          = 1'b1;
    v[DIV_LSB +: DIV_W] = div;
    return v;
  endfunction

  function automatic logic od_is_div2(input logic [OD_W-1:0] od);
    return od == OD_DIV2;
  endfunction

endpackage

// File: rtl/pbs_timer.sv
module pbs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && $past(cnt_o) != '0) |-> $past(clr_i));

endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
  import pbs_pkg::*;
#(
  parameter int RST_HOLD     = 4,
  parameter int LOCK_TIMEOUT = 400_000_000,
  parameter int CNT_W        = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             od_ok_i,
  input  logic             lock_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             ev_load_o,
  output logic             ev_cfg_bad_o,
  output logic             ev_byp_on_o,
  output logic             ev_rst_on_o,
  output logic             ev_rst_off_o,
  output logic             ev_lock_o,
  output logic             ev_timeout_o,
  output logic [1:0]       gasket_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_to_o,
  output logic             err_cfg_o
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD - 1);
  localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(LOCK_TIMEOUT - 1);

  pbs_state_t st, nx;
  logic       idle_like;
  logic       ev_start;
  logic       hold_hit;
  logic       wait_last;

  always_comb begin
    idle_like    = (st == S_IDLE) || (st == S_DONE) || (st == S_ERR);
    ev_start     = start_i && !stop_i && idle_like;
    hold_hit     = (st == S_HOLD) && (cnt_i == HOLD_LAST);
    wait_last    = (st == S_WAIT) && (cnt_i == TO_LAST);
    ev_load_o    = (st == S_CHECK) && od_ok_i && !stop_i;
    ev_cfg_bad_o = (st == S_CHECK) && !od_ok_i && !stop_i;
    ev_byp_on_o  = (st == S_BYPASS) && !stop_i;
    ev_rst_on_o  = (st == S_RSTON) && !stop_i;
    ev_rst_off_o = hold_hit && !stop_i;
    ev_lock_o    = (st == S_WAIT) && lock_i && !stop_i;
    ev_timeout_o = wait_last && !lock_i && !stop_i;
    cnt_clr_o    = !((st == S_HOLD) || (st == S_WAIT)) || ev_rst_off_o;
    busy_o       = !idle_like;
  end

  always_comb begin
    nx = st;
    if (stop_i) begin
      nx = S_IDLE;
    end else begin
      unique case (st)
        S_IDLE, S_DONE, S_ERR: if (start_i) nx = S_CHECK;
        S_CHECK:               nx = od_ok_i ? S_BYPASS : S_ERR;
        S_BYPASS:              nx = S_RSTON;
        S_RSTON:               nx = S_HOLD;
        S_HOLD:                if (hold_hit) nx = S_WAIT;
        S_WAIT: begin
          if (lock_i)         nx = S_DONE;
          else if (wait_last) nx = S_ERR;
        end
        default:               nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      gasket_o  <= GASKET_OFF;
      done_o    <= 1'b0;
      err_to_o  <= 1'b0;
      err_cfg_o <= 1'b0;
    end else begin
      st <= nx;
      if (stop_i) begin
        gasket_o  <= GASKET_OFF;
        done_o    <= 1'b0;
        err_to_o  <= 1'b0;
        err_cfg_o <= 1'b0;
      end else if (ev_start) begin
        gasket_o  <= GASKET_ON;
        done_o    <= 1'b0;
        err_to_o  <= 1'b0;
        err_cfg_o <= 1'b0;
      end else begin
        if (ev_lock_o)    done_o    <= 1'b1;
        if (ev_timeout_o) err_to_o  <= 1'b1;
        if (ev_cfg_bad_o) err_cfg_o <= 1'b1;
      end
    end
  end

  // R6
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> (cnt_i <= HOLD_LAST));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stop_i) |=> (gasket_o == GASKET_ON));

  // R2
  start_gasket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && !busy_o) |=> (gasket_o == GASKET_ON && busy_o));

endmodule

// File: rtl/pbs_pll_regs.sv
module pbs_pll_regs
  import pbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load_i,
  input  logic              ev_byp_on_i,
  input  logic              ev_rst_on_i,
  input  logic              ev_rst_off_i,
  input  logic              ev_lock_i,
  input  logic [FB_W-1:0]   fbdiv_i,
  input  logic [DIV_W-1:0]  core_div_i,
  input  logic [DIV_W-1:0]  mcu_div_i,
  input  logic [OD_W-1:0]   outdiv_i,
  output logic [CTRL_W-1:0] pll_ctrl_o,
  output logic [CLKW_W-1:0] core_word_o,
  output logic [CLKW_W-1:0] mcu_word_o
);

  logic            rst_q, por_in_q, pwr_por_q, byp_q;
  logic [FB_W-1:0] fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q       <= 1'b0;
      por_in_q    <= 1'b1;
      pwr_por_q   <= 1'b1;
      byp_q       <= 1'b0;
      fb_q        <= '0;
      core_word_o <= '0;
      mcu_word_o  <= '0;
    end else begin
      if (ev_load_i) begin
        fb_q        <= fbdiv_i;
        por_in_q    <= 1'b0;
        pwr_por_q   <= 1'b0;
        core_word_o <= clk_word(core_div_i);
        mcu_word_o  <= clk_word(mcu_div_i);
      end
      if (ev_byp_on_i)  byp_q <= 1'b1;
      if (ev_lock_i)    byp_q <= 1'b0;
      if (ev_rst_on_i)  rst_q <= 1'b1;
      if (ev_rst_off_i) rst_q <= 1'b0;
    end
  end

  always_comb pll_ctrl_o = pll_word(rst_q, por_in_q, pwr_por_q, byp_q, fb_q, outdiv_i);

  // R5
  byp_covers_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> byp_q);

  // R5
  byp_before_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(byp_q));

  // R4
  load_por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_i |=> (!por_in_q && !pwr_por_q && core_word_o[SRC_BIT] && mcu_word_o[SRC_BIT]));

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pbs_pkg::*;
#(
  parameter int RST_HOLD     = 4,
  parameter int LOCK_TIMEOUT = 400_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        lock_i,
  input  logic [6:0]  fbdiv_i,
  input  logic [5:0]  core_div_i,
  input  logic [5:0]  mcu_div_i,
  input  logic [1:0]  outdiv_i,
  output logic [17:0] pll_ctrl_o,
  output logic [9:0]  core_clk_ctrl_o,
  output logic [9:0]  mcu_clk_ctrl_o,
  output logic [1:0]  gasket_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_timeout_o,
  output logic        err_cfg_o
);

  localparam int SPAN  = (RST_HOLD > LOCK_TIMEOUT) ? RST_HOLD : LOCK_TIMEOUT;
  localparam int CNT_W = $clog2(SPAN + 1);

  logic             od_ok;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;
  logic             ev_load, ev_cfg_bad, ev_byp_on, ev_rst_on, ev_rst_off;
  logic             ev_lock, ev_timeout;

  always_comb od_ok = od_is_div2(outdiv_i);

  pbs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  pbs_fsm #(
    .RST_HOLD     (RST_HOLD),
    .LOCK_TIMEOUT (LOCK_TIMEOUT),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .od_ok_i      (od_ok),
    .lock_i       (lock_i),
    .cnt_i        (cnt),
    .cnt_clr_o    (cnt_clr),
    .ev_load_o    (ev_load),
    .ev_cfg_bad_o (ev_cfg_bad),
    .ev_byp_on_o  (ev_byp_on),
    .ev_rst_on_o  (ev_rst_on),
    .ev_rst_off_o (ev_rst_off),
    .ev_lock_o    (ev_lock),
    .ev_timeout_o (ev_timeout),
    .gasket_o     (gasket_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_to_o     (err_timeout_o),
    .err_cfg_o    (err_cfg_o)
  );

  pbs_pll_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_load_i    (ev_load),
    .ev_byp_on_i  (ev_byp_on),
    .ev_rst_on_i  (ev_rst_on),
    .ev_rst_off_i (ev_rst_off),
    .ev_lock_i    (ev_lock),
    .fbdiv_i      (fbdiv_i),
    .core_div_i   (core_div_i),
    .mcu_div_i    (mcu_div_i),
    .outdiv_i     (outdiv_i),
    .pll_ctrl_o   (pll_ctrl_o),
    .core_word_o  (core_clk_ctrl_o),
    .mcu_word_o   (mcu_clk_ctrl_o)
  );

  // R8
  byp_falls_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_ctrl_o[BYP_BIT]) |-> ($past(lock_i) && done_o));

  // R10
  stop_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (gasket_o == GASKET_OFF && !busy_o && !done_o));

  // R8
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_timeout_o, err_cfg_o}));

  // R3
  cfg_err_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_bad |=> (err_cfg_o && $stable(pll_ctrl_o[15:0]) && $stable(core_clk_ctrl_o)));

  // R9
  timeout_keeps_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (err_timeout_o && pll_ctrl_o[BYP_BIT] && !done_o));

endmodule

// File: tb/pll_bringup_seq_test.sv
`timescale 1ns/1ps
module pll_bringup_seq_test;

  localparam int HOLD = 3;
  localparam int TO   = 24;
  localparam int LAST = 3 + HOLD + TO;   // last lock sample edge index
  localparam int NEVER = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, lock_i = 1'b0;
  logic [6:0]  fbdiv_i = '0;
  logic [5:0]  core_div_i = '0, mcu_div_i = '0;
  logic [1:0]  outdiv_i = 2'd1;
  logic [17:0] pll_ctrl_o;
  logic [9:0]  core_clk_ctrl_o, mcu_clk_ctrl_o;
  logic [1:0]  gasket_o;
  logic        busy_o, done_o, err_timeout_o, err_cfg_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pll_bringup_seq #(.RST_HOLD(HOLD), .LOCK_TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .lock_i(lock_i),
    .fbdiv_i(fbdiv_i), .core_div_i(core_div_i), .mcu_div_i(mcu_div_i), .outdiv_i(outdiv_i),
    .pll_ctrl_o(pll_ctrl_o), .core_clk_ctrl_o(core_clk_ctrl_o), .mcu_clk_ctrl_o(mcu_clk_ctrl_o),
    .gasket_o(gasket_o), .busy_o(busy_o), .done_o(done_o),
    .err_timeout_o(err_timeout_o), .err_cfg_o(err_cfg_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected PLL word: od[17:16], 0[15], fb[14:8], 0[7:4], byp, pwrpor, porin, rst
  function automatic logic [17:0] model_pll(input bit r, input bit p, input bit w,
                                            input bit b, input logic [6:0] fb,
                                            input logic [1:0] od);
    return {od, 1'b0, fb, 4'b0000, b, w, p, r};
  endfunction

  function automatic logic [9:0] model_clk(input logic [5:0] d);
    return {d, 3'b000, 1'b1};
  endfunction

  function automatic bit lock_at(input int t, input int lk, input int p0, input int p1);
    return (t >= lk) || (t >= p0 && t <= p1);
  endfunction

  task automatic run_seq(input logic [6:0] fb, input logic [5:0] cd, input logic [5:0] md,
                         input logic [1:0] od, input int lk, input int p0, input int p1,
                         input int stop_at, input int extra_start, input string tag);
    logic [17:0] pre;
    logic [9:0]  pre_c, pre_m;
    int end_t, lock_t;
    bit timed_out, bad_rst, bad_byp, bad_busy, bad_gas;
    pre = pll_ctrl_o; pre_c = core_clk_ctrl_o; pre_m = mcu_clk_ctrl_o;
    timed_out = 0; lock_t = -1;
    bad_rst = 0; bad_byp = 0; bad_busy = 0; bad_gas = 0;
    if (od != 2'd1) end_t = 1;
    else begin
      for (int t = 4 + HOLD; t <= LAST; t++)
        if (lock_t < 0 && lock_at(t, lk, p0, p1)) lock_t = t;
      if (lock_t >= 0) end_t = lock_t;
      else begin end_t = LAST; timed_out = 1; end
    end
    fbdiv_i = fb; core_div_i = cd; mcu_div_i = md; outdiv_i = od;
    start_i = 1'b1; stop_i = 1'b0; lock_i = lock_at(0, lk, p0, p1);
    for (int c = 1; c <= end_t + 2; c++) begin
      int t;
      bit e_rst, e_byp;
      @(negedge clk);
      t = c - 1;
      start_i = (c == extra_start);
      stop_i  = (c == stop_at);
      lock_i  = lock_at(c, lk, p0, p1);
      if (stop_at > 0 && t == stop_at) begin
        // R10
        check(gasket_o == 2'b00 && !busy_o && !done_o && !err_timeout_o && !err_cfg_o,
              "R10", {tag, " stop teardown"}, {gasket_o, busy_o, done_o}, 0);
        stop_i = 1'b0; start_i = 1'b0; lock_i = 1'b0;
        return;
      end
      if (od != 2'd1) begin
        e_rst = pre[0]; e_byp = pre[3];
      end else begin
        e_rst = (t >= 3 && t <= 2 + HOLD) ? 1'b1 : (t < 3 ? pre[0] : 1'b0);
        e_byp = (t < 2) ? pre[3] : (timed_out || t < end_t);
      end
      if (pll_ctrl_o[0] != e_rst) bad_rst = 1;
      if (pll_ctrl_o[3] != e_byp) bad_byp = 1;
      if (busy_o != (t < end_t)) bad_busy = 1;
      if (gasket_o != 2'b11) bad_gas = 1;
    end
    start_i = 1'b0; lock_i = 1'b0;
    // R2 R11
    check(!bad_gas, "R2", {tag, " gasket open during run"}, gasket_o, 2'b11);
    check(!bad_busy, "R11", {tag, " busy timeline"}, busy_o, 0);
    // R5 R6
    check(!bad_rst, "R6", {tag, " reset pulse timeline"}, pll_ctrl_o[0], 0);
    // R5 R8 R9
    check(!bad_byp, "R5", {tag, " bypass timeline"}, pll_ctrl_o[3], 0);
    if (od != 2'd1) begin
      // R3
      check(err_cfg_o && !done_o && !err_timeout_o, "R3", {tag, " cfg error flag"},
            {err_cfg_o, done_o, err_timeout_o}, 3'b100);
      check(pll_ctrl_o[15:0] == pre[15:0] && core_clk_ctrl_o == pre_c && mcu_clk_ctrl_o == pre_m,
            "R3", {tag, " PLL untouched"}, pll_ctrl_o, pre);
    end else begin
      // R4 R8 R9 (R7: lock before 4+HOLD is never counted)
      check(pll_ctrl_o == model_pll(0, 0, 0, timed_out, fb, od), "R4",
            {tag, " final PLL word"}, pll_ctrl_o, model_pll(0, 0, 0, timed_out, fb, od));
      check(core_clk_ctrl_o == model_clk(cd) && mcu_clk_ctrl_o == model_clk(md), "R4",
            {tag, " clock words"}, {core_clk_ctrl_o, mcu_clk_ctrl_o}, {model_clk(cd), model_clk(md)});
      check(done_o == !timed_out && err_timeout_o == timed_out && !err_cfg_o,
            timed_out ? "R9" : "R8", {tag, " status"},
            {done_o, err_timeout_o}, {!timed_out, timed_out});
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [6:0] rfb;
    logic [5:0] rcd, rmd;
    logic [1:0] rod;
    int rlk, rp0;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(gasket_o == 2'b00 && !busy_o && !done_o && !err_timeout_o && !err_cfg_o,
          "R1", "status after reset", {gasket_o, busy_o, done_o}, 0);
    check(pll_ctrl_o == model_pll(0, 1, 1, 0, 0, outdiv_i) &&
          core_clk_ctrl_o == 0 && mcu_clk_ctrl_o == 0, "R1", "PLL word after reset",
          pll_ctrl_o, model_pll(0, 1, 1, 0, 0, outdiv_i));

    run_seq(7'd50, 6'd5, 6'd10, 2'd1, 10, NEVER, 0, -1, -1, "basic");
    run_seq(7'd33, 6'd3, 6'd7, 2'd1, 0, NEVER, 0, -1, -1, "R7 lock-early-held");
    run_seq(7'd90, 6'd63, 6'd1, 2'd1, LAST, NEVER, 0, -1, -1, "R9 lock-at-last");
    run_seq(7'd91, 6'd2, 6'd2, 2'd1, LAST + 1, NEVER, 0, -1, -1, "R9 lock-too-late");
    run_seq(7'd40, 6'd4, 6'd8, 2'd1, NEVER, 3, 3 + HOLD, -1, -1, "R7 early-pulse");
    run_seq(7'd25, 6'd9, 6'd9, 2'd0, 5, NEVER, 0, -1, -1, "R3 div0");
    run_seq(7'd26, 6'd9, 6'd9, 2'd3, 5, NEVER, 0, -1, -1, "R3 div3");
    run_seq(7'd60, 6'd11, 6'd12, 2'd1, 15, NEVER, 0, -1, 5, "R11 start-while-busy");
    run_seq(7'd61, 6'd13, 6'd14, 2'd1, NEVER, NEVER, 0, 12, -1, "R10 stop-in-wait");
    run_seq(7'd62, 6'd15, 6'd16, 2'd1, NEVER, NEVER, 0, 2, 2, "R10 stop-beats-start");
    run_seq(7'd70, 6'd17, 6'd18, 2'd1, 8, NEVER, 0, -1, -1, "R11 restart");

    // R10 stop after done
    start_i = 1'b0; stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(gasket_o == 2'b00 && !done_o && !busy_o, "R10", "stop after done",
          {gasket_o, done_o}, 0);

    for (int i = 0; i < 20; i++) begin
      rfb = 7'($urandom_range(25, 125));
      rcd = 6'($urandom_range(1, 63));
      rmd = 6'($urandom_range(1, 63));
      rod = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
      rlk = ($urandom_range(0, 4) == 0) ? NEVER : $urandom_range(0, LAST + 3);
      rp0 = $urandom_range(0, 3 + HOLD);
      run_seq(rfb, rcd, rmd, rod, rlk, rp0, rp0 + $urandom_range(0, 2), -1, -1, "R8 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule